// File: doc/BRIEF.md
# Debug port command sequencer

This block sits behind the serial shifter of a debug link. Each transfer carries one 16-bit word from the host into the block and one 17-bit response out of it. A response is a status bit followed by 16 data bits. The host's words are command opcodes, address operands or filler. The block decodes the opcodes and runs two commands. The first reads a 32-bit entry of a 16-entry register file. The second reads memory in byte, word or long size over a request/acknowledge bus that can signal a fault.

Results are pipelined. A command's result is shifted out in the transfers that follow its opcode, and the last result transfer already carries the next opcode. Not-ready, bus-error and illegal-command conditions are reported inside the response stream. Each is marked by the status bit and a fixed data code. After an error or illegal response, the word received in that same transfer is decoded as a new command.

Top module: `dbgcmd_seq`

## Requirements
- R1: After reset the pending response is not-ready (status 1, data 0x0000) and no memory request is raised. The first transfer after reset returns not-ready and decodes its word as a command.
- R2: A word whose bits [15:4] equal 0x218 is a register read when the core is halted. Bits [3:0] select the register: bit 3 set means an address register, and bits [2:0] give the number. That index is driven on `rf_addr`. The next two transfers return status 0 with bits [31:16] first, then bits [15:0].
- R3: The word received in the final transfer of a result is decoded as the next command.
- R4: A register read issued while `core_halted` is low returns one bus-error response (status 1, data 0x0001). That transfer's word is decoded as the next command.
- R5: Any other opcode does nothing and returns one illegal response (status 1, data 0xFFFF). It raises no memory request, and that transfer's word is decoded as the next command.
- R6: A memory read opcode has 0x19 in bits [15:8], a size in bits [7:6] (00 byte, 01 word, 10 long; 11 is illegal) and zero in bits [5:0]. The next two transfers carry address bits [31:16], then [15:0], and both return not-ready. The request then presents that address on `mem_addr` and the size code on `mem_size`, held steady until acknowledged.
- R7: While a memory access is outstanding, every transfer returns not-ready and its word is ignored.
- R8: A long read returns status 0 with bits [31:16], then bits [15:0]. A word read returns status 0 with data bits [15:0] in one transfer. A byte read returns status 0 with the byte in data bits [7:0]; the upper data byte has no defined value.
- R9: An access acknowledged with `mem_err` returns one bus-error response (status 1, data 0x0001), and that transfer's word is decoded as the next command.
- R10: Each memory read command raises exactly one request. The request stays high until the cycle `mem_ack` is seen and is low on the following cycle.
- R11: The status bit is 0 only on result words. With status 1 the data is always one of 0x0000, 0x0001 or 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_halted | input | 1 | High while the processor core is halted |
| xfer | input | 1 | One-cycle strobe marking a completed transfer |
| cmd_in | input | 16 | Word received from the host in this transfer |
| resp_out | output | 17 | Response for the current transfer: status bit, then 16 data bits |
| rf_addr | output | 4 | Register file read index |
| rf_data | input | 32 | Register file read data, combinational from `rf_addr` |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory read address |
| mem_size | output | 2 | Memory read size code (00 byte, 01 word, 10 long) |
| mem_ack | input | 1 | Memory access finished |
| mem_err | input | 1 | Access faulted, valid with `mem_ack` |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |

## Verification
The assertions rely on the bus pulsing `mem_ack` for a single cycle, only while `mem_req` is high, and raising `mem_err` only together with it. They also rely on the host's response to be taken from `resp_out` in the cycle the strobe is high. The bench memory model acknowledges once per request after a chosen latency and faults on any address whose top nibble is 0xE. The host model spaces strobes at least two idle cycles apart, so the single-cycle register fetch always ends before the next transfer. It changes `core_halted` only just before the transfer that carries the opcode it is meant for.

// File: rtl/dbgcmd_pkg.sv
`timescale 1ns/1ps
package dbgcmd_pkg;
  localparam int WORD_W    = 16;
  localparam int RESP_W    = WORD_W + 1;
  localparam int LONG_W    = 2 * WORD_W;
  localparam int REG_IDX_W = 4;
  localparam int BYTE_W    = 8;

  localparam logic [WORD_W-REG_IDX_W-1:0] REGRD_TAG = 12'h218;
  localparam logic [7:0]                  MEMRD_TAG = 8'h19;

  localparam logic [WORD_W-1:0] CODE_NOTRDY = 16'h0000;
  localparam logic [WORD_W-1:0] CODE_BERR   = 16'h0001;
  localparam logic [WORD_W-1:0] CODE_ILL    = 16'hFFFF;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_RSVD = 2'b11
  } xsize_e;

  typedef enum logic [1:0] {
    OP_REGRD,
    OP_REGBERR,
    OP_MEMRD,
    OP_ILLEGAL
  } opkind_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RWAIT,
    ST_HIWORD,
    ST_LOWORD,
    ST_ADDRH,
    ST_ADDRL,
    ST_MWAIT,
    ST_BERR,
    ST_ILL
  } seq_st_e;
endpackage

// File: rtl/dbgcmd_decode.sv
`timescale 1ns/1ps
module dbgcmd_decode
  import dbgcmd_pkg::*;
(
  input  logic [WORD_W-1:0]    word,
  input  logic                 halted,
  output opkind_e              kind,
  output logic [REG_IDX_W-1:0] idx,
  output xsize_e               size
);
  logic is_reg;
  logic is_mem;

  assign is_reg = (word[WORD_W-1:REG_IDX_W] == REGRD_TAG);
  assign is_mem = (word[WORD_W-1:8] == MEMRD_TAG) && (word[5:0] == 6'd0) &&
                  (word[7:6] != SZ_RSVD);

  always_comb begin
    idx  = word[REG_IDX_W-1:0];
    size = xsize_e'(word[7:6]);
    if (is_reg)      kind = halted ? OP_REGRD : OP_REGBERR;
    else if (is_mem) kind = OP_MEMRD;
    else             kind = OP_ILLEGAL;
  end
endmodule

// File: rtl/dbgcmd_encode.sv
`timescale 1ns/1ps
module dbgcmd_encode
  import dbgcmd_pkg::*;
(
  input  seq_st_e           st,
  input  logic [LONG_W-1:0] res,
  output logic [RESP_W-1:0] resp
);
  always_comb begin
    case (st)
      ST_HIWORD: resp = {1'b0, res[LONG_W-1:WORD_W]};
      ST_LOWORD: resp = {1'b0, res[WORD_W-1:0]};
      ST_BERR:   resp = {1'b1, CODE_BERR};
      ST_ILL:    resp = {1'b1, CODE_ILL};
      default:   resp = {1'b1, CODE_NOTRDY};
    endcase
  end
endmodule

// File: rtl/dbgcmd_seq.sv
`timescale 1ns/1ps
module dbgcmd_seq
  import dbgcmd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 core_halted,
  input  logic                 xfer,
  input  logic [WORD_W-1:0]    cmd_in,
  output logic [RESP_W-1:0]    resp_out,
  output logic [REG_IDX_W-1:0] rf_addr,
  input  logic [LONG_W-1:0]    rf_data,
  output logic                 mem_req,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [1:0]           mem_size,
  input  logic                 mem_ack,
  input  logic                 mem_err,
  input  logic [LONG_W-1:0]    mem_rdata
);
  localparam int ADDR_FULL_W = 2 * WORD_W;

  seq_st_e                st_q, st_n;
  logic [LONG_W-1:0]      res_q, res_n;
  logic [REG_IDX_W-1:0]   idx_q, idx_n;
  xsize_e                 sz_q, sz_n;
  logic [WORD_W-1:0]      ahi_q, ahi_n;
  logic [ADDR_W-1:0]      addr_n;
  logic [ADDR_FULL_W-1:0] addr_full;
  logic                   accept_op;
  opkind_e                dec_kind;
  logic [REG_IDX_W-1:0]   dec_idx;
  xsize_e                 dec_size;
  logic [RESP_W-1:0]      resp_n;

  dbgcmd_decode u_decode (
    .word   (cmd_in),
    .halted (core_halted),
    .kind   (dec_kind),
    .idx    (dec_idx),
    .size   (dec_size)
  );

  dbgcmd_encode u_encode (
    .st   (st_n),
    .res  (res_n),
    .resp (resp_n)
  );

  assign addr_full = {ahi_q, cmd_in};
  assign accept_op = (st_q == ST_IDLE) || (st_q == ST_LOWORD) ||
                     (st_q == ST_BERR) || (st_q == ST_ILL);
  assign rf_addr   = idx_q;
  assign mem_size  = sz_q;

  always_comb begin
    st_n   = st_q;
    res_n  = res_q;
    idx_n  = idx_q;
    sz_n   = sz_q;
    ahi_n  = ahi_q;
    addr_n = mem_addr;
    case (st_q)
      ST_IDLE, ST_LOWORD, ST_BERR, ST_ILL: begin
        if (xfer) begin
          case (dec_kind)
            OP_REGRD: begin
              st_n  = ST_RWAIT;
              idx_n = dec_idx;
            end
            OP_REGBERR: st_n = ST_BERR;
            OP_MEMRD: begin
              st_n = ST_ADDRH;
              sz_n = dec_size;
            end
            default: st_n = ST_ILL;
          endcase
        end
      end
      ST_RWAIT: begin
        st_n  = ST_HIWORD;
        res_n = rf_data;
      end
      ST_HIWORD: if (xfer) st_n = ST_LOWORD;
      ST_ADDRH: begin
        if (xfer) begin
          ahi_n = cmd_in;
          st_n  = ST_ADDRL;
        end
      end
      ST_ADDRL: begin
        if (xfer) begin
          addr_n = addr_full[ADDR_W-1:0];
          st_n   = ST_MWAIT;
        end
      end
      ST_MWAIT: begin
        if (mem_ack) begin
          if (mem_err) begin
            st_n = ST_BERR;
          end else begin
            case (sz_q)
              SZ_LONG: begin
                st_n  = ST_HIWORD;
                res_n = mem_rdata;
              end
              SZ_WORD: begin
                st_n  = ST_LOWORD;
                res_n = {{(LONG_W-WORD_W){1'b0}}, mem_rdata[WORD_W-1:0]};
              end
              default: begin
                st_n  = ST_LOWORD;
                res_n = {{(LONG_W-BYTE_W){1'b0}}, mem_rdata[BYTE_W-1:0]};
              end
            endcase
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      res_q    <= '0;
      idx_q    <= '0;
      sz_q     <= SZ_BYTE;
      ahi_q    <= '0;
      mem_addr <= '0;
      mem_req  <= 1'b0;
      resp_out <= {1'b1, CODE_NOTRDY};
    end else begin
      st_q     <= st_n;
      res_q    <= res_n;
      idx_q    <= idx_n;
      sz_q     <= sz_n;
      ahi_q    <= ahi_n;
      mem_addr <= addr_n;
      mem_req  <= (st_n == ST_MWAIT);
      resp_out <= resp_n;
    end
  end
endmodule

// File: rtl/dbgcmd_seq_chk.sv
`timescale 1ns/1ps
module dbgcmd_seq_chk
  import dbgcmd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 core_halted,
  input logic                 xfer,
  input logic [WORD_W-1:0]    cmd_in,
  input logic [RESP_W-1:0]    resp_out,
  input logic [REG_IDX_W-1:0] rf_addr,
  input logic                 mem_req,
  input logic                 mem_ack,
  input logic                 mem_err,
  input logic [ADDR_W-1:0]    mem_addr,
  input logic [1:0]           mem_size,
  input logic                 accept_op
);
  logic rst_seen;

  always_ff @(posedge clk) rst_seen <= rst;

  always @(negedge clk) begin
    if (rst_seen) begin
      AST_RESET_STATE: assert (resp_out == {1'b1, CODE_NOTRDY} && !mem_req) // R1
        else $error("reset state wrong");
    end
  end

  AST_REG_FETCH: assert property (@(posedge clk) disable iff (rst)
    xfer && accept_op && cmd_in[WORD_W-1:REG_IDX_W] == REGRD_TAG && core_halted
    |=> resp_out == {1'b1, CODE_NOTRDY} && rf_addr == $past(cmd_in[REG_IDX_W-1:0])); // R2

  AST_REG_BERR: assert property (@(posedge clk) disable iff (rst)
    xfer && accept_op && cmd_in[WORD_W-1:REG_IDX_W] == REGRD_TAG && !core_halted
    |=> resp_out == {1'b1, CODE_BERR}); // R4

  AST_ILL_NOOP: assert property (@(posedge clk) disable iff (rst)
    xfer && accept_op && cmd_in[WORD_W-1:WORD_W-4] == 4'hF
    |=> resp_out == {1'b1, CODE_ILL} && !mem_req); // R5

  AST_REQ_STEADY: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_size)); // R6

  AST_PEND_NOTRDY: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> resp_out == {1'b1, CODE_NOTRDY}); // R7

  AST_FAULT_BERR: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_ack && mem_err |=> resp_out == {1'b1, CODE_BERR}); // R9

  AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_ack |=> !mem_req); // R10

  AST_STATUS_CODES: assert property (@(posedge clk) disable iff (rst)
    resp_out[WORD_W] |-> (resp_out[WORD_W-1:0] == CODE_NOTRDY ||
                          resp_out[WORD_W-1:0] == CODE_BERR ||
                          resp_out[WORD_W-1:0] == CODE_ILL)); // R11
endmodule

bind dbgcmd_seq dbgcmd_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .core_halted (core_halted),
  .xfer        (xfer),
  .cmd_in      (cmd_in),
  .resp_out    (resp_out),
  .rf_addr     (rf_addr),
  .mem_req     (mem_req),
  .mem_ack     (mem_ack),
  .mem_err     (mem_err),
  .mem_addr    (mem_addr),
  .mem_size    (mem_size),
  .accept_op   (accept_op)
);

// File: tb/dbgcmd_seq_test.sv
`timescale 1ns/1ps
module dbgcmd_seq_test;
  localparam int GAP = 2;
  localparam logic [31:0] FULL = 32'h1FFFF;
  localparam logic [31:0] NR   = 32'h10000;

  typedef struct {
    int          kind;   // 0 register read, 1 memory read, 2 illegal
    logic [15:0] op;
    logic        halted;
    logic [31:0] addr;
    int          lat;
  } cmd_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        core_halted = 1'b1;
  logic        xfer = 1'b0;
  logic [15:0] cmd_in = '0;
  logic [16:0] resp_out;
  logic [3:0]  rf_addr;
  logic [31:0] rf_data;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic [1:0]  mem_size;
  logic        mem_ack = 1'b0;
  logic        mem_err = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [31:0] regs [16];

  int compared = 0;
  int mismatched = 0;
  int lat_next = 0;
  int wait_cnt = 0;
  int req_count = 0;
  logic        req_prev = 1'b0;
  logic [31:0] seen_addr = '0;
  logic [1:0]  seen_size = '0;

  always #2.5 clk = ~clk;
  assign rf_data = regs[rf_addr];

  dbgcmd_seq uut (
    .clk(clk), .rst(rst), .core_halted(core_halted), .xfer(xfer),
    .cmd_in(cmd_in), .resp_out(resp_out), .rf_addr(rf_addr), .rf_data(rf_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] mem_val(input logic [31:0] a);
    return {a[15:0] ^ 16'hC3A5, a[31:16] + 16'h0F1E};
  endfunction

  function automatic bit mem_fault(input logic [31:0] a);
    return a[31:28] == 4'hE;
  endfunction

  function automatic bit legal_op(input logic [15:0] w);
    return (w[15:4] == 12'h218) || (w[15:8] == 8'h19 && w[5:0] == 6'd0 && w[7:6] != 2'b11);
  endfunction

  // memory responder: one acknowledge per request after lat_next idle cycles
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      mem_err = 1'b0;
    end else if (mem_req) begin
      if (!req_prev) begin
        req_count++;
        seen_addr = mem_addr;
        seen_size = mem_size;
        wait_cnt  = lat_next;
      end
      if (wait_cnt == 0) begin
        mem_ack   = 1'b1;
        mem_err   = mem_fault(mem_addr);
        mem_rdata = mem_val(mem_addr);
      end else begin
        wait_cnt--;
      end
    end
    req_prev = mem_req;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input logic [31:0] mask);
    compared++;
    if ((act & mask) !== (exp & mask)) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act & mask, exp & mask);
    end
  endtask

  task automatic do_xfer(input logic [15:0] w, output logic [16:0] r);
    r = resp_out;
    cmd_in = w;
    xfer = 1'b1;
    @(negedge clk);
    xfer = 1'b0;
    cmd_in = 16'h0;
    repeat (GAP) @(negedge clk);
  endtask

  function automatic cmd_t mk_reg(input logic [3:0] idx, input logic halted);
    cmd_t c;
    c.kind = 0; c.op = {12'h218, idx}; c.halted = halted; c.addr = '0; c.lat = 0;
    return c;
  endfunction

  function automatic cmd_t mk_mem(input logic [1:0] sz, input logic [31:0] a, input int lat);
    cmd_t c;
    c.kind = 1; c.op = {8'h19, sz, 6'd0}; c.halted = 1'b1; c.addr = a; c.lat = lat;
    return c;
  endfunction

  function automatic cmd_t mk_ill(input logic [15:0] w);
    cmd_t c;
    c.kind = 2; c.op = w; c.halted = 1'b1; c.addr = '0; c.lat = 0;
    return c;
  endfunction

  function automatic cmd_t gen_cmd();
    logic [15:0] w;
    logic [31:0] a;
    case ($urandom_range(0, 2))
      0: return mk_reg(4'($urandom_range(0, 15)), $urandom_range(0, 3) != 0);
      1: begin
        a = $urandom();
        if ($urandom_range(0, 4) == 0) a[31:28] = 4'hE;
        else if (a[31:28] == 4'hE) a[31:28] = 4'h1;
        return mk_mem(2'($urandom_range(0, 2)), a, $urandom_range(0, 6));
      end
      default: begin
        w = 16'($urandom());
        while (legal_op(w)) w = 16'($urandom());
        return mk_ill(w);
      end
    endcase
  endfunction

  task automatic run_cmd(input cmd_t c, input cmd_t nx);
    logic [16:0] r;
    logic [31:0] v;
    int polls;
    int rc0;
    rc0 = req_count;
    case (c.kind)
      0: begin
        v = regs[c.op[3:0]];
        if (c.halted) begin
          do_xfer(16'h0000, r);
          check("R2 R11 high half", 32'(r), {15'd0, 1'b0, v[31:16]}, FULL);
          core_halted = nx.halted;
          do_xfer(nx.op, r);
          check("R2 R3 low half", 32'(r), {15'd0, 1'b0, v[15:0]}, FULL);
        end else begin
          core_halted = nx.halted;
          do_xfer(nx.op, r);
          check("R4 R11 not halted", 32'(r), 32'h10001, FULL);
        end
        check("R5 register read makes no request", 32'(req_count - rc0), 32'd0, FULL);
      end
      1: begin
        lat_next = c.lat;
        v = mem_val(c.addr);
        do_xfer(c.addr[31:16], r);
        check("R6 high operand not-ready", 32'(r), NR, FULL);
        do_xfer(c.addr[15:0], r);
        check("R6 low operand not-ready", 32'(r), NR, FULL);
        if (c.op[7:6] != 2'b10 || mem_fault(c.addr)) core_halted = nx.halted;
        polls = 0;
        do begin
          do_xfer((c.op[7:6] == 2'b10 && !mem_fault(c.addr)) ? 16'h0000 : nx.op, r);
          polls++;
        end while (r == 17'h10000 && polls < 40);
        check("R6 address", seen_addr, c.addr, 32'hFFFFFFFF);
        check("R6 size", 32'(seen_size), 32'(c.op[7:6]), FULL);
        if (c.lat >= 4) check("R7 outstanding access answered not-ready", 32'(polls > 1), 32'd1, FULL);
        if (mem_fault(c.addr)) begin
          check("R9 R11 fault", 32'(r), 32'h10001, FULL);
        end else if (c.op[7:6] == 2'b10) begin
          check("R8 long high", 32'(r), {15'd0, 1'b0, v[31:16]}, FULL);
          core_halted = nx.halted;
          do_xfer(nx.op, r);
          check("R8 R3 long low", 32'(r), {15'd0, 1'b0, v[15:0]}, FULL);
        end else if (c.op[7:6] == 2'b01) begin
          check("R8 word", 32'(r), {15'd0, 1'b0, v[15:0]}, FULL);
        end else begin
          check("R8 byte", 32'(r), {15'd0, 1'b0, 8'h00, v[7:0]}, 32'h100FF);
        end
        check("R10 one request", 32'(req_count - rc0), 32'd1, FULL);
        check("R10 request released", 32'(mem_req), 32'd0, FULL);
      end
      default: begin
        core_halted = nx.halted;
        do_xfer(nx.op, r);
        check("R5 R11 illegal", 32'(r), 32'h1FFFF, FULL);
        check("R5 no request", 32'(req_count - rc0), 32'd0, FULL);
      end
    endcase
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    cmd_t dir [12];
    cmd_t cur;
    cmd_t nx;
    logic [16:0] r;
    void'($urandom(32'd51966));
    for (int i = 0; i < 16; i++) regs[i] = $urandom();
    dir[0]  = mk_reg(4'hA, 1'b1);
    dir[1]  = mk_reg(4'h2, 1'b0);
    dir[2]  = mk_ill(16'hFFFF);
    dir[3]  = mk_ill(16'h19C0);
    dir[4]  = mk_ill(16'h1901);
    dir[5]  = mk_mem(2'b00, 32'h1234_5679, 0);
    dir[6]  = mk_mem(2'b01, 32'h0000_FFFE, 6);
    dir[7]  = mk_mem(2'b10, 32'h8000_0004, 5);
    dir[8]  = mk_mem(2'b10, 32'hE000_0010, 4);
    dir[9]  = mk_reg(4'h3, 1'b1);
    dir[10] = mk_ill(16'h2170);
    dir[11] = mk_reg(4'hF, 1'b1);

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset response", 32'(resp_out), NR, FULL);
    check("R1 reset request", 32'(mem_req), 32'd0, FULL);

    cur = dir[0];
    core_halted = cur.halted;
    do_xfer(cur.op, r);
    check("R1 first transfer not-ready", 32'(r), NR, FULL);
    for (int i = 1; i < 72; i++) begin
      nx = (i < 12) ? dir[i] : gen_cmd();
      run_cmd(cur, nx);
      cur = nx;
    end
    run_cmd(cur, mk_ill(16'hFFFF));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule